// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to a two-wire I2C bus and never drives it. Both lines are sampled on the system clock through a synchronizer. From the synchronized samples the monitor finds the bus conditions that open and close a transfer, assembles the address and data bytes, and reports the acknowledge that follows each byte. It emits one event per item: a 4-bit code, a byte field and a single-cycle valid strobe.

The first byte after any opening condition is the address. Its least significant bit sets the direction of the transfer, and each later data byte is tagged with that direction. A static select input chooses whether addresses are reported as the 7-bit value or as the raw byte. For each transfer the monitor also counts the sampled bits and the system-clock cycles from the opening condition to the closing one. It presents both counts in the cycle of the closing event, so software can derive the bitrate.

Top module: `i2c_observer`

## Requirements
- R1: While rst_n is low and in the cycle after, evt_valid and xfer_valid are 0. After reset the monitor waits for an opening condition, and a rising SDA with SCL high in that state produces no event.
- R2: In the idle state, an SDA fall while SCL is high in both the previous and the current synchronized sample emits code 1 (start) with byte 0x00.
- R3: After an opening condition, 8 SCL rising edges are shifted in MSB first. On the 8th edge the monitor emits code 6 (address read) when the byte's LSB is 1, or code 7 (address write) when it is 0.
- R4: When addr_shift is 1 the address event carries the byte shifted right by one with a zero MSB. When addr_shift is 0 it carries the full received byte.
- R5: The 9th SCL rising edge after each byte emits code 4 (ACK) when SDA is 0 or code 5 (NACK) when SDA is 1, with byte 0x00.
- R6: Each later group of 8 SCL rising edges emits code 8 (data read) when the address LSB was 1, or code 9 (data write) when it was 0, with the byte MSB first.
- R7: After the first acknowledge, an SDA fall with SCL high emits code 2 (repeated start), even in the middle of a byte. The next byte is then treated as an address.
- R8: After the first acknowledge, an SDA rise with SCL high emits code 3 (stop) and returns to idle. xfer_valid pulses in that same cycle.
- R9: While the address byte or an acknowledge bit is being received, SDA changes with SCL high are ignored and only SCL rising edges are acted on.
- R10: xfer_bits is the number of SCL rising edges sampled in the address or data phases since the latest start or repeated start. Acknowledge bits are not counted, and the rise just before the stop is counted. xfer_cycles is the number of clock cycles from the cycle that detected that opening condition to the cycle that detected the stop, both included.
- R11: Both transfer counters hold at their all-ones value rather than wrapping.
- R12: When SCL rises in the same sample that SDA changes, the change counts only as a bit sample. No start or stop is recognized.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| addr_shift | input | 1 | 1 = 7-bit address output, 0 = raw address byte |
| evt_valid | output | 1 | One-cycle strobe for an event |
| evt_code | output | 4 | Event code (1..9, see requirements) |
| evt_byte | output | DW | Byte of an address or data event, zero otherwise |
| xfer_valid | output | 1 | Pulses with the stop event |
| xfer_bits | output | CNT_W | Bits sampled in the finished transfer |
| xfer_cycles | output | CNT_W | Clock cycles of the finished transfer |

## Verification
A rising SCL edge and an SDA transition can land in the same synchronized sample. In that case the bit-sampling path and the condition detector would both claim the cycle. The bench provokes this by changing both lines at the same clock: once in idle with SDA falling, and once inside a data byte with SDA rising. The resulting event list must show the bit sampled in the byte and no start or stop. The stop event and the transfer report also fall in one cycle. An extra narrow-counter instance confirms that both counters saturate there.

// File: rtl/i2c_obs_pkg.sv
// Shared types for the passive I2C monitor.
package i2c_obs_pkg;

    // Event codes presented on evt_code.
    typedef enum logic [3:0] {
        EV_NONE    = 4'd0,
        EV_START   = 4'd1,
        EV_RSTART  = 4'd2,
        EV_STOP    = 4'd3,
        EV_ACK     = 4'd4,
        EV_NACK    = 4'd5,
        EV_ADDR_RD = 4'd6,
        EV_ADDR_WR = 4'd7,
        EV_DATA_RD = 4'd8,
        EV_DATA_WR = 4'd9
    } evt_code_t;

    // Decoder phase.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_DATA
    } mon_state_t;

    // Line activity seen in one synchronized sample.
    typedef struct packed {
        logic rise;     // SCL went 0 -> 1
        logic start_c;  // SDA fell, SCL high before and now
        logic stop_c;   // SDA rose, SCL high before and now
        logic sda;      // current synchronized SDA level
    } line_evt_t;

endpackage

// File: rtl/i2c_obs_sync.sv
// Synchronizes SCL and SDA and derives per-sample line activity.
// Assumes: both lines idle high; STAGES >= 2. Start/stop require SCL high in
// the previous and current sample, so an SCL rise always wins over an SDA change.
module i2c_obs_sync
    import i2c_obs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      scl_raw,
    input  logic      sda_raw,
    output line_evt_t line_ev
);
    localparam int NL = 2;   // index 0 = SCL, 1 = SDA

    logic [NL-1:0] raw;
    logic [NL-1:0] cur;
    logic [NL-1:0] prev;

    assign raw = {sda_raw, scl_raw};

    for (genvar g = 0; g < NL; g++) begin : g_line
        logic [STAGES-1:0] stg;
        // Shift chain moving the asynchronous level into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg <= '1;
            else        stg <= {stg[STAGES-2:0], raw[g]};
        end
        assign cur[g] = stg[STAGES-1];
    end

    // Hold the previous synchronized sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= cur;
    end

    // Classify the transition between the previous and current sample.
    always_comb begin
        line_ev.rise    = cur[0] & ~prev[0];
        line_ev.start_c = cur[0] & prev[0] & prev[1] & ~cur[1];
        line_ev.stop_c  = cur[0] & prev[0] & ~prev[1] & cur[1];
        line_ev.sda     = cur[1];
    end
endmodule

// File: rtl/i2c_obs_decode.sv
// Protocol state machine: finds start/stop, assembles bytes, tags them with
// role and direction, reports acknowledges. Registered event outputs.
// Assumes one line_ev per clock; hit_* pulses are combinational for the meter.
module i2c_obs_decode
    import i2c_obs_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  line_evt_t     line_ev,
    input  logic          addr_shift,
    output logic          evt_valid,
    output logic [3:0]    evt_code,
    output logic [DW-1:0] evt_byte,
    output logic          hit_start,
    output logic          hit_bit,
    output logic          hit_stop
);
    localparam int BCW = $clog2(DW);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    mon_state_t    state, state_n;
    logic [DW-1:0] shreg, shreg_n;
    logic [BCW-1:0] bcnt, bcnt_n;
    logic          dir_rd, dir_rd_n;
    logic          ev_v_n;
    evt_code_t     code_n;
    logic [DW-1:0] byte_n;
    logic [DW-1:0] full;
    logic          take_bit;

    assign full = {shreg[DW-2:0], line_ev.sda};

    // Next-state, byte assembly and event selection.
    always_comb begin
        state_n   = state;
        shreg_n   = shreg;
        bcnt_n    = bcnt;
        dir_rd_n  = dir_rd;
        ev_v_n    = 1'b0;
        code_n    = EV_NONE;
        byte_n    = '0;
        hit_start = 1'b0;
        hit_stop  = 1'b0;
        take_bit  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (line_ev.start_c) begin
                    ev_v_n    = 1'b1;
                    code_n    = EV_START;
                    state_n   = ST_ADDR;
                    bcnt_n    = '0;
                    hit_start = 1'b1;
                end
            end
            ST_ADDR: begin
                take_bit = line_ev.rise;
            end
            ST_ACK: begin
                if (line_ev.rise) begin
                    ev_v_n  = 1'b1;
                    code_n  = line_ev.sda ? EV_NACK : EV_ACK;
                    state_n = ST_DATA;
                    bcnt_n  = '0;
                end
            end
            ST_DATA: begin
                if (line_ev.rise) begin
                    take_bit = 1'b1;
                end else if (line_ev.start_c) begin
                    ev_v_n    = 1'b1;
                    code_n    = EV_RSTART;
                    state_n   = ST_ADDR;
                    bcnt_n    = '0;
                    hit_start = 1'b1;
                end else if (line_ev.stop_c) begin
                    ev_v_n   = 1'b1;
                    code_n   = EV_STOP;
                    state_n  = ST_IDLE;
                    hit_stop = 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase

        if (take_bit) begin
            shreg_n = full;
            if (bcnt == LAST_BIT) begin
                bcnt_n  = '0;
                state_n = ST_ACK;
                ev_v_n  = 1'b1;
                if (state == ST_ADDR) begin
                    dir_rd_n = full[0];
                    code_n   = full[0] ? EV_ADDR_RD : EV_ADDR_WR;
                    byte_n   = addr_shift ? {1'b0, full[DW-1:1]} : full;
                end else begin
                    code_n = dir_rd ? EV_DATA_RD : EV_DATA_WR;
                    byte_n = full;
                end
            end else begin
                bcnt_n = bcnt + 1'b1;
            end
        end
    end

    assign hit_bit = take_bit;

    // Decoder state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            bcnt   <= '0;
            dir_rd <= 1'b0;
        end else begin
            state  <= state_n;
            shreg  <= shreg_n;
            bcnt   <= bcnt_n;
            dir_rd <= dir_rd_n;
        end
    end

    // Registered event outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_code  <= EV_NONE;
            evt_byte  <= '0;
        end else begin
            evt_valid <= ev_v_n;
            evt_code  <= code_n;
            evt_byte  <= byte_n;
        end
    end
endmodule

// File: rtl/i2c_obs_meter.sv
// Counts sampled bits and clock cycles of one transfer, saturating.
// Assumes hit_start, hit_bit and hit_stop are mutually exclusive.
module i2c_obs_meter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_start,
    input  logic             hit_bit,
    input  logic             hit_stop,
    output logic             xfer_valid,
    output logic [CNT_W-1:0] xfer_bits,
    output logic [CNT_W-1:0] xfer_cycles
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             active;
    logic [CNT_W-1:0] run_bits;
    logic [CNT_W-1:0] run_cyc;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    // Running counters; the detection cycle of the start counts as one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            run_bits <= '0;
            run_cyc  <= '0;
        end else if (hit_start) begin
            active   <= 1'b1;
            run_bits <= '0;
            run_cyc  <= CNT_W'(1);
        end else if (active) begin
            run_cyc <= sat_inc(run_cyc);
            if (hit_bit) run_bits <= sat_inc(run_bits);
            if (hit_stop) active <= 1'b0;
        end
    end

    // Report the totals in the cycle of the stop event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_valid  <= 1'b0;
            xfer_bits   <= '0;
            xfer_cycles <= '0;
        end else begin
            xfer_valid <= hit_stop;
            if (hit_stop) begin
                xfer_bits   <= run_bits;
                xfer_cycles <= sat_inc(run_cyc);
            end
        end
    end
endmodule

// File: rtl/i2c_observer.sv
// Top of the passive I2C monitor: synchronizer, decoder and transfer meter.
// Assumes addr_shift is static while an address byte is received.
module i2c_observer #(
    parameter int STAGES = 2,
    parameter int DW     = 8,
    parameter int CNT_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             addr_shift,
    output logic             evt_valid,
    output logic [3:0]       evt_code,
    output logic [DW-1:0]    evt_byte,
    output logic             xfer_valid,
    output logic [CNT_W-1:0] xfer_bits,
    output logic [CNT_W-1:0] xfer_cycles
);
    i2c_obs_pkg::line_evt_t line_ev;
    logic hit_start, hit_bit, hit_stop;

    i2c_obs_sync #(.STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .line_ev (line_ev)
    );

    i2c_obs_decode #(.DW(DW)) u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_ev    (line_ev),
        .addr_shift (addr_shift),
        .evt_valid  (evt_valid),
        .evt_code   (evt_code),
        .evt_byte   (evt_byte),
        .hit_start  (hit_start),
        .hit_bit    (hit_bit),
        .hit_stop   (hit_stop)
    );

    i2c_obs_meter #(.CNT_W(CNT_W)) u_meter (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_start   (hit_start),
        .hit_bit     (hit_bit),
        .hit_stop    (hit_stop),
        .xfer_valid  (xfer_valid),
        .xfer_bits   (xfer_bits),
        .xfer_cycles (xfer_cycles)
    );
endmodule

// File: rtl/i2c_observer_chk.sv
// Assertion checker for i2c_observer, attached by bind.
module i2c_observer_chk #(
    parameter int DW    = 8,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_shift,
    input logic             evt_valid,
    input logic [3:0]       evt_code,
    input logic [DW-1:0]    evt_byte,
    input logic             xfer_valid,
    input logic [CNT_W-1:0] xfer_cycles
);
    // R2: only defined codes are ever strobed
    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_code >= 4'd1 && evt_code <= 4'd9));

    // R8: a transfer report only comes with a stop event
    a_r8_report_with_stop: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (evt_valid && evt_code == 4'd3));

    // R8: every stop event carries a transfer report
    a_r8_stop_has_report: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code == 4'd3) |-> xfer_valid);

    // R5: condition and acknowledge events carry a zero byte
    a_r5_ctrl_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code >= 4'd1 && evt_code <= 4'd5) |-> (evt_byte == '0));

    // R4: a 7-bit address never has its top bit set
    a_r4_shifted_msb: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == 4'd6 || evt_code == 4'd7) && $past(addr_shift))
            |-> !evt_byte[DW-1]);

    // R11: a saturating cycle count never reads zero
    a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> (xfer_cycles != '0));
endmodule

bind i2c_observer i2c_observer_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_shift  (addr_shift),
    .evt_valid   (evt_valid),
    .evt_code    (evt_code),
    .evt_byte    (evt_byte),
    .xfer_valid  (xfer_valid),
    .xfer_cycles (xfer_cycles)
);

// File: tb/i2c_observer_test.sv
// Self-checking bench: sweeps all 7-bit addresses plus targeted corner cases.
module i2c_observer_test;
    localparam int H = 4;   // clock cycles per bus half-phase

    logic clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic shift = 1'b0;

    logic        evt_valid, xfer_valid;
    logic [3:0]  evt_code;
    logic [7:0]  evt_byte;
    logic [31:0] xfer_bits, xfer_cycles;
    logic        n_evt_valid, n_xfer_valid;
    logic [3:0]  n_evt_code;
    logic [7:0]  n_evt_byte;
    logic [4:0]  n_bits, n_cycles;

    i2c_observer uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .addr_shift(shift),
        .evt_valid(evt_valid), .evt_code(evt_code), .evt_byte(evt_byte),
        .xfer_valid(xfer_valid), .xfer_bits(xfer_bits), .xfer_cycles(xfer_cycles)
    );

    i2c_observer #(.CNT_W(5)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda), .addr_shift(shift),
        .evt_valid(n_evt_valid), .evt_code(n_evt_code), .evt_byte(n_evt_byte),
        .xfer_valid(n_xfer_valid), .xfer_bits(n_bits), .xfer_cycles(n_cycles)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int t_start = 0;
    int t_stop = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Capture of observed events and reports.
    int         cap_n = 0;
    logic [3:0] cap_code [0:255];
    logic [7:0] cap_byte [0:255];
    int         xv_n = 0;
    logic [31:0] xv_bits, xv_cyc;
    logic [4:0]  nv_bits, nv_cyc;

    always @(negedge clk) begin
        if (evt_valid) begin
            cap_code[cap_n % 256] = evt_code;
            cap_byte[cap_n % 256] = evt_byte;
            cap_n++;
        end
        if (xfer_valid) begin
            xv_n++;
            xv_bits = xfer_bits;
            xv_cyc  = xfer_cycles;
        end
        if (n_xfer_valid) begin
            nv_bits = n_bits;
            nv_cyc  = n_cycles;
        end
    end

    // Expected event list.
    logic [3:0] ex_code [0:31];
    logic [7:0] ex_byte [0:31];
    int ex_n = 0;
    int base = 0;
    int xv_base = 0;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic begin_case();
        base = cap_n;
        xv_base = xv_n;
        ex_n = 0;
    endtask

    task automatic expect_ev(input logic [3:0] c, input logic [7:0] b);
        ex_code[ex_n] = c;
        ex_byte[ex_n] = b;
        ex_n++;
    endtask

    task automatic check_val(input string req, input string what,
                             input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_events(input string req, input string what);
        bit bad;
        int got;
        wait_cyc(24);
        got = cap_n - base;
        checks++;
        bad = 1'b0;
        if (got != ex_n) begin
            bad = 1'b1;
            $display("FAIL %s %s event count actual=%0d expected=%0d", req, what, got, ex_n);
        end
        for (int i = 0; i < ex_n && !bad; i++) begin
            if (cap_code[(base + i) % 256] !== ex_code[i] ||
                cap_byte[(base + i) % 256] !== ex_byte[i]) begin
                bad = 1'b1;
                $display("FAIL %s %s event %0d actual=%0d/%02h expected=%0d/%02h",
                         req, what, i, cap_code[(base + i) % 256],
                         cap_byte[(base + i) % 256], ex_code[i], ex_byte[i]);
            end
        end
        if (bad) failures++;
    endtask

    // Bus drivers; all changes made just after a falling clock edge.
    task automatic bus_start();
        sda = 1'b0; t_start = cyc; wait_cyc(H);
        scl = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_bit(input logic b);
        sda = b;    wait_cyc(H);
        scl = 1'b1; wait_cyc(H);
        scl = 1'b0; wait_cyc(H);
    endtask

    task automatic bus_byte(input logic [7:0] b, input logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(b[i]);
        bus_bit(ack);
    endtask

    task automatic bus_stop();
        sda = 1'b0; wait_cyc(H);
        scl = 1'b1; wait_cyc(H);
        sda = 1'b1; t_stop = cyc; wait_cyc(H);
    endtask

    task automatic bus_rstart();
        sda = 1'b1; wait_cyc(H);
        scl = 1'b1; wait_cyc(H);
        sda = 1'b0; t_start = cyc; wait_cyc(H);
        scl = 1'b0; wait_cyc(H);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        logic rw;
        logic [7:0] d1, d2, abyte;
        int sat;

        // R1: reset state
        wait_cyc(6);
        check_val("R1", "evt_valid in reset", evt_valid, 0);
        check_val("R1", "xfer_valid in reset", xfer_valid, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check_val("R1", "evt_valid after reset", evt_valid, 0);
        wait_cyc(10);

        // R1: a stop pattern in idle is ignored
        begin_case();
        scl = 1'b0; wait_cyc(H);
        sda = 1'b0; wait_cyc(H);
        scl = 1'b1; wait_cyc(H);
        sda = 1'b1; wait_cyc(H);
        check_events("R1", "stop in idle");

        // R12: SCL rise with SDA fall together in idle is no start
        begin_case();
        scl = 1'b0; wait_cyc(H);
        scl = 1'b1; sda = 1'b0; wait_cyc(H);
        sda = 1'b1; wait_cyc(H);
        check_events("R12", "simultaneous edge in idle");

        // R2 R3 R4 R5 R6 R8 R10 R11: sweep of all addresses
        for (int a = 0; a < 128; a++) begin
            rw    = a[0] ^ a[3];
            shift = a[1];
            d1    = 8'(a * 3 + 1);
            d2    = ~8'(a);
            abyte = {7'(a), rw};
            wait_cyc(2);
            begin_case();
            expect_ev(4'd1, 8'h00);
            expect_ev(rw ? 4'd6 : 4'd7, shift ? {1'b0, 7'(a)} : abyte);
            expect_ev(4'd4, 8'h00);
            expect_ev(rw ? 4'd8 : 4'd9, d1);
            expect_ev(4'd4, 8'h00);
            expect_ev(rw ? 4'd8 : 4'd9, d2);
            expect_ev(4'd5, 8'h00);
            expect_ev(4'd3, 8'h00);
            bus_start();
            bus_byte(abyte, 1'b0);
            bus_byte(d1, 1'b0);
            bus_byte(d2, 1'b1);
            bus_stop();
            check_events("R3", "address sweep");
            check_val("R8", "report count", xv_n - xv_base, 1);
            check_val("R10", "bits", xv_bits, 25);
            check_val("R10", "cycles", xv_cyc, t_stop - t_start + 1);
            check_val("R11", "narrow bits", nv_bits, 25);
            check_val("R11", "narrow cycles saturate", nv_cyc, 31);
        end

        // R7: repeated start after a byte and in the middle of a byte
        shift = 1'b0;
        begin_case();
        expect_ev(4'd1, 8'h00);
        expect_ev(4'd7, 8'hA0);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd9, 8'h12);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd2, 8'h00);
        expect_ev(4'd6, 8'hA1);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd2, 8'h00);
        expect_ev(4'd7, 8'h3C);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd9, 8'h5A);
        expect_ev(4'd5, 8'h00);
        expect_ev(4'd3, 8'h00);
        bus_start();
        bus_byte(8'hA0, 1'b0);
        bus_byte(8'h12, 1'b0);
        bus_rstart();
        bus_byte(8'hA1, 1'b0);
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_rstart();
        bus_byte(8'h3C, 1'b0);
        bus_byte(8'h5A, 1'b1);
        bus_stop();
        check_events("R7", "repeated starts");
        check_val("R10", "bits after repeated start", xv_bits, 17);
        check_val("R10", "cycles after repeated start", xv_cyc, t_stop - t_start + 1);

        // R9: a stop pattern inside the address byte is ignored
        begin_case();
        expect_ev(4'd1, 8'h00);
        expect_ev(4'd6, 8'hAD);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd3, 8'h00);
        bus_start();
        bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        sda = 1'b0; wait_cyc(H);
        scl = 1'b1; wait_cyc(H);
        sda = 1'b1; wait_cyc(H);
        scl = 1'b0; wait_cyc(H);
        bus_bit(1'b1); bus_bit(1'b1); bus_bit(1'b0); bus_bit(1'b1);
        bus_bit(1'b0);
        bus_stop();
        check_events("R9", "stop pattern in address phase");
        check_val("R10", "bits with ignored stop", xv_bits, 9);

        // R12: SCL rise with SDA rise together inside a data byte is a bit
        shift = 1'b1;
        begin_case();
        expect_ev(4'd1, 8'h00);
        expect_ev(4'd7, 8'h20);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd9, 8'h80);
        expect_ev(4'd4, 8'h00);
        expect_ev(4'd3, 8'h00);
        bus_start();
        bus_byte(8'h40, 1'b0);
        sda = 1'b0; wait_cyc(H);
        scl = 1'b1; sda = 1'b1; wait_cyc(H);
        scl = 1'b0; wait_cyc(H);
        for (int i = 0; i < 7; i++) bus_bit(1'b0);
        bus_bit(1'b0);
        bus_stop();
        check_events("R12", "simultaneous edge in data");
        check_val("R12", "bits with simultaneous edge", xv_bits, 17);

        // R11: bit counter saturation on the narrow instance
        shift = 1'b0;
        begin_case();
        bus_start();
        bus_byte(8'h10, 1'b0);
        bus_byte(8'h01, 1'b0);
        bus_byte(8'h02, 1'b0);
        bus_byte(8'h03, 1'b1);
        bus_stop();
        wait_cyc(24);
        sat = 33;
        check_val("R10", "wide bits", xv_bits, sat);
        check_val("R11", "narrow bits saturate", nv_bits, 31);

        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            finish_run();
        end
    end
endmodule